// File: doc/BRIEF.md
# Inclusive L2 Snoop Response Filter

This block sits beside an inclusive second-level cache and chooses the cache's answer to every operation snooped from the system bus. It holds a small directory model with one entry per cache line: a tag, a MESI state and one "may be in L1" bit for each 32-byte granule of the line. The cache controller writes an entry whenever it allocates, changes or drops a line. Each snooped address is checked against that directory in the same cycle. The answer is one of three: stay silent, assert the shared response, or retry the bus operation.

When the processor's first-level cache may hold the target granule, the retry comes with a forward request. The request carries the address and operation type to the processor side and is held there until the processor side accepts it. Because the cache is inclusive, a directory miss proves the L1 has no copy. A clear presence bit proves the same for that granule. In either case the processor is never disturbed. Shared lines answered by plain or atomic reads are also handled in the L2 alone.

Only one forward can be outstanding. While it is pending, a snoop to the same granule is retried with no other action. A snoop that would need a second forward is retried, and no new forward is started.

Top module: `incl_snoop_filter`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle in which `snp_valid` is high, and low otherwise. `rsp_retry` and `rsp_shared` are low whenever `rsp_valid` is low.
- R2: A snoop that matches no live directory entry gives no retry, no shared response and no forward. This covers a tag mismatch and also state I (encoding 00).
- R3: A hit in E (10) or M (11) state whose granule presence bit is set gives a retry, no shared response, and a forward of the snooped address and operation type.
- R4: A hit in S (01) state with a read (000) or read-atomic (001) gives only the shared response, whatever the presence bit holds.
- R5: A hit in S state with read-with-intent-to-modify (010), kill (011), flush (100) or clean (101), and with the presence bit set, gives a retry and a forward.
- R6: A hit whose granule presence bit is clear is never forwarded. With a read or read-atomic it gives the shared response. With operation types 010 to 101 it gives no response at all.
- R7: The undefined operation types 110 and 111 are retried on every hit. They are forwarded only when the presence bit is set.
- R8: With the default sizes, address bit 5 selects the granule, bits 8:6 select the directory entry and bits 15:9 are the tag. A directory write replaces the whole entry: tag, state and both presence bits. Reset leaves every entry empty.
- R9: While a forward is pending and `fwd_ready` is low, a snoop to the same 32-byte granule is retried, with no shared response and no new forward.
- R10: While a forward is pending, a snoop that would need another forward is retried, and `fwd_addr` and `fwd_op` hold their values until `fwd_ready` is seen.
- R11: When `fwd_ready` is high in the same cycle as a snoop that needs a forward, the pending forward completes. The new forward is presented in the next cycle.
- R12: `rsp_retry` and `rsp_shared` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Snooped bus operation present this cycle |
| snp_addr | input | ADDR_W | Snooped byte address |
| snp_op | input | 3 | Snooped operation type |
| upd_en | input | 1 | Write one directory entry |
| upd_addr | input | ADDR_W | Address of the line being written |
| upd_state | input | 2 | New MESI state (I=00, S=01, E=10, M=11) |
| upd_mark | input | LINE_BYTES/GRAN_BYTES | New presence bits, one per granule, bit 0 for the lowest granule |
| rsp_valid | output | 1 | Response slot for the previous cycle's snoop |
| rsp_retry | output | 1 | Retry the snooped operation |
| rsp_shared | output | 1 | Assert the shared response |
| fwd_valid | output | 1 | Forward request pending toward the processor |
| fwd_ready | input | 1 | Processor side accepts the pending forward |
| fwd_addr | output | ADDR_W | Address of the forwarded operation |
| fwd_op | output | 3 | Type of the forwarded operation |

## Verification
A corrupted tag, state or presence bit shows at the ports on the very next cycle. A silent answer turns into a retry, or a forward fails to appear where one is due, or one appears where the presence bit forbids it. A wrong pending-forward state appears within one snoop. It shows as a missing retry on a granule that is still outstanding, or as a changed `fwd_addr` before `fwd_ready`. The sweep writes every state and presence pattern into the directory, then snoops both granules of the line with every operation code, on a hit and on a miss. The sweep then covers the collisions with a pending forward.

// File: rtl/isf_pkg.sv
package isf_pkg;

  localparam logic [1:0] ST_I = 2'b00;
  localparam logic [1:0] ST_S = 2'b01;
  localparam logic [1:0] ST_E = 2'b10;
  localparam logic [1:0] ST_M = 2'b11;

  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_READ_A = 3'd1;
  localparam logic [2:0] OP_RWITM  = 3'd2;
  localparam logic [2:0] OP_KILL   = 3'd3;
  localparam logic [2:0] OP_FLUSH  = 3'd4;
  localparam logic [2:0] OP_CLEAN  = 3'd5;

  localparam int unsigned GRAN_BYTES_FIXED = 32;

  typedef struct packed {
    logic retry;
    logic shared;
    logic fwd;
  } snp_resp_t;

  function automatic logic op_is_defined(input logic [2:0] op);
    return op <= OP_CLEAN;
  endfunction

  function automatic logic op_is_readlike(input logic [2:0] op);
    return (op == OP_READ) || (op == OP_READ_A);
  endfunction

endpackage

// File: rtl/isf_dir.sv
module isf_dir #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned SETS       = 8,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned GRAN_BYTES = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  upd_en,
  input  logic [ADDR_W-1:0]                     upd_addr,
  input  logic [1:0]                            upd_state,
  input  logic [LINE_BYTES/GRAN_BYTES-1:0]      upd_mark,
  input  logic [ADDR_W-1:0]                     lk_addr,
  output logic                                  lk_hit,
  output logic [1:0]                            lk_state,
  output logic                                  lk_mark
);
  import isf_pkg::*;

  localparam int unsigned GPL    = LINE_BYTES / GRAN_BYTES;
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned GOFF_W = $clog2(GRAN_BYTES);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned GSEL_W = (GPL > 1) ? $clog2(GPL) : 1;

  // entry storage: written synchronously, read asynchronously (distributed RAM)
  logic [TAG_W-1:0] tag_mem  [SETS];
  logic [1:0]       st_mem   [SETS];
  logic [GPL-1:0]   mark_mem [SETS];

  // liveness kept in flops so that reset can empty the directory at once
  logic [SETS-1:0]  live_q;

  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag;
  logic [GPL-1:0]   rd_marks;

  assign wr_idx = upd_addr[OFF_W +: IDX_W];
  assign wr_tag = upd_addr[ADDR_W-1 -: TAG_W];
  assign rd_idx = lk_addr[OFF_W +: IDX_W];
  assign rd_tag = lk_addr[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      st_mem[wr_idx]   <= upd_state;
      mark_mem[wr_idx] <= upd_mark;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else if (upd_en) begin
      live_q[wr_idx] <= (upd_state != ST_I);
    end
  end

  assign rd_marks = mark_mem[rd_idx];
  assign lk_state = st_mem[rd_idx];
  assign lk_hit   = live_q[rd_idx] && (tag_mem[rd_idx] == rd_tag) && (st_mem[rd_idx] != ST_I);

  generate
    if (GPL > 1) begin : g_multi_gran
      logic [GSEL_W-1:0] gsel;
      assign gsel    = lk_addr[GOFF_W +: GSEL_W];
      assign lk_mark = rd_marks[gsel];
    end else begin : g_single_gran
      assign lk_mark = rd_marks[0];
    end
  endgenerate

endmodule

// File: rtl/isf_decide.sv
module isf_decide (
  input  logic                 hit,
  input  logic [1:0]           state,
  input  logic                 mark,
  input  logic [2:0]           op,
  input  logic                 busy,
  input  logic                 busy_same_gran,
  output isf_pkg::snp_resp_t   resp
);
  import isf_pkg::*;

  snp_resp_t raw;
  logic      is_shared_line;

  assign is_shared_line = (state == ST_S);

  always_comb begin
    raw = '0;
    if (busy_same_gran) begin
      // a forward to this granule is still in flight: hold the bus off
      raw.retry = 1'b1;
    end else if (hit) begin
      if (!op_is_defined(op)) begin
        raw.retry = 1'b1;
        raw.fwd   = mark;
      end else if (mark) begin
        if (is_shared_line && op_is_readlike(op)) begin
          raw.shared = 1'b1;
        end else begin
          raw.retry = 1'b1;
          raw.fwd   = 1'b1;
        end
      end else if (op_is_readlike(op)) begin
        raw.shared = 1'b1;
      end
    end
  end

  always_comb begin
    resp = raw;
    if (busy) begin
      resp.fwd = 1'b0;
    end
  end

endmodule

// File: rtl/isf_fwd.sv
module isf_fwd #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned GRAN_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [2:0]        load_op,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              busy,
  output logic              busy_same_gran,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [2:0]        fwd_op
);
  localparam int unsigned GOFF_W = $clog2(GRAN_BYTES);
  localparam int unsigned GNUM_W = ADDR_W - GOFF_W;

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        op_q;

  assign busy           = valid_q && !fwd_ready;
  assign busy_same_gran = busy && (probe_addr[ADDR_W-1 -: GNUM_W] == addr_q[ADDR_W-1 -: GNUM_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
    end else if (fwd_ready) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= load_addr;
      op_q   <= load_op;
    end
  end

  assign fwd_valid = valid_q;
  assign fwd_addr  = addr_q;
  assign fwd_op    = op_q;

endmodule

// File: rtl/incl_snoop_filter.sv
module incl_snoop_filter #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned SETS       = 8,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned GRAN_BYTES = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             snp_valid,
  input  logic [ADDR_W-1:0]                snp_addr,
  input  logic [2:0]                       snp_op,
  input  logic                             upd_en,
  input  logic [ADDR_W-1:0]                upd_addr,
  input  logic [1:0]                       upd_state,
  input  logic [LINE_BYTES/GRAN_BYTES-1:0] upd_mark,
  output logic                             rsp_valid,
  output logic                             rsp_retry,
  output logic                             rsp_shared,
  output logic                             fwd_valid,
  input  logic                             fwd_ready,
  output logic [ADDR_W-1:0]                fwd_addr,
  output logic [2:0]                       fwd_op
);
  import isf_pkg::*;

  logic       lk_hit_w;
  logic [1:0] lk_state_w;
  logic       lk_mark_w;
  logic       busy_w;
  logic       busy_same_w;
  snp_resp_t  dec_w;
  logic       dec_fwd_w;
  logic       fwd_load_w;

  isf_dir #(
    .ADDR_W(ADDR_W), .SETS(SETS), .LINE_BYTES(LINE_BYTES), .GRAN_BYTES(GRAN_BYTES)
  ) dir_i (
    .clk(clk), .rst(rst),
    .upd_en(upd_en), .upd_addr(upd_addr), .upd_state(upd_state), .upd_mark(upd_mark),
    .lk_addr(snp_addr), .lk_hit(lk_hit_w), .lk_state(lk_state_w), .lk_mark(lk_mark_w)
  );

  isf_decide dec_i (
    .hit(lk_hit_w), .state(lk_state_w), .mark(lk_mark_w), .op(snp_op),
    .busy(busy_w), .busy_same_gran(busy_same_w), .resp(dec_w)
  );

  assign dec_fwd_w  = dec_w.fwd;
  assign fwd_load_w = snp_valid && dec_fwd_w;

  isf_fwd #(
    .ADDR_W(ADDR_W), .GRAN_BYTES(GRAN_BYTES)
  ) fwd_i (
    .clk(clk), .rst(rst),
    .load(fwd_load_w), .load_addr(snp_addr), .load_op(snp_op),
    .probe_addr(snp_addr), .busy(busy_w), .busy_same_gran(busy_same_w),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_op(fwd_op)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_retry  <= 1'b0;
      rsp_shared <= 1'b0;
    end else begin
      rsp_valid  <= snp_valid;
      rsp_retry  <= snp_valid && dec_w.retry;
      rsp_shared <= snp_valid && dec_w.shared;
    end
  end

endmodule

// File: rtl/incl_snoop_filter_chk.sv
module incl_snoop_filter_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              snp_valid,
  input logic              rsp_valid,
  input logic              rsp_retry,
  input logic              rsp_shared,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic [2:0]        fwd_op,
  input logic              lk_mark_w,
  input logic              dec_fwd_w
);

  a_r1_resp_follows: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> rsp_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !snp_valid |=> !rsp_valid);

  a_r1_quiet_slot: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_retry && !rsp_shared));

  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rsp_retry && rsp_shared));

  a_r6_clear_mark_no_fwd: assert property (@(posedge clk) disable iff (rst)
    !lk_mark_w |-> !dec_fwd_w);

  a_r3_fwd_with_retry: assert property (@(posedge clk) disable iff (rst)
    $rose(fwd_valid) |-> rsp_retry);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_op)));

endmodule

bind incl_snoop_filter incl_snoop_filter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .snp_valid(snp_valid),
  .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_shared(rsp_shared),
  .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_op(fwd_op),
  .lk_mark_w(lk_mark_w), .dec_fwd_w(dec_fwd_w)
);

// File: tb/incl_snoop_filter_tb_top.sv
`timescale 1ns/1ps
module incl_snoop_filter_tb_top;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              snp_valid = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [2:0]        snp_op = '0;
  logic              upd_en = 1'b0;
  logic [ADDR_W-1:0] upd_addr = '0;
  logic [1:0]        upd_state = '0;
  logic [1:0]        upd_mark = '0;
  logic              rsp_valid, rsp_retry, rsp_shared;
  logic              fwd_valid;
  logic              fwd_ready = 1'b0;
  logic [ADDR_W-1:0] fwd_addr;
  logic [2:0]        fwd_op;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  incl_snoop_filter dut_i (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_op(snp_op),
    .upd_en(upd_en), .upd_addr(upd_addr), .upd_state(upd_state), .upd_mark(upd_mark),
    .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_shared(rsp_shared),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_op(fwd_op)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int idx, input int g, input int off);
    return ADDR_W'((tag << 9) | (idx << 6) | (g << 5) | (off & 31));
  endfunction

  // expected {retry, shared, fwd} for an idle forward slot
  function automatic logic [2:0] model(input int st, input int mk, input int g, input int op, input bit tag_eq);
    bit hit, mark, rd;
    hit  = tag_eq && (st != 0);
    mark = ((mk >> g) & 1) != 0;
    rd   = (op == 0) || (op == 1);
    if (!hit) return 3'b000;                 // R2
    if (op > 5) return {1'b1, 1'b0, mark};   // R7
    if (!mark) return rd ? 3'b010 : 3'b000;  // R6
    if (st == 1 && rd) return 3'b010;        // R4
    return 3'b101;                           // R3, R5
  endfunction

  task automatic do_upd(input logic [ADDR_W-1:0] a, input int st, input int mk);
    upd_en = 1'b1; upd_addr = a; upd_state = 2'(st); upd_mark = 2'(mk);
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic do_snoop(input logic [ADDR_W-1:0] a, input int op);
    snp_valid = 1'b1; snp_addr = a; snp_op = 3'(op);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic do_release();
    fwd_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] a, la, lb;
    logic [2:0] e;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rsp_valid", 32'(rsp_valid), 0);
    check("R10 reset fwd_valid", 32'(fwd_valid), 0);

    // R8: empty directory after reset
    do_snoop(mk_addr(5, 3, 1, 0), 2);
    check("R8 empty dir", 32'({rsp_retry, rsp_shared, fwd_valid}), 0);
    check("R1 rsp after snoop", 32'(rsp_valid), 1);

    // exhaustive sweep
    n = 0;
    for (int st = 0; st < 4; st++)
      for (int mk = 0; mk < 4; mk++)
        for (int g = 0; g < 2; g++)
          for (int op = 0; op < 8; op++)
            for (int h = 0; h < 2; h++) begin
              int tag, idx;
              tag = (n * 13) & 127;
              idx = n & 7;
              do_upd(mk_addr(tag, idx, 0, 0), st, mk);
              check("R1 idle no rsp", 32'(rsp_valid), 0);
              a = mk_addr((h != 0) ? tag : (tag ^ 1), idx, g, n * 7);
              do_snoop(a, op);
              e = model(st, mk, g, op, h != 0);
              check($sformatf("R2-7 sweep st%0d mk%0d g%0d op%0d h%0d", st, mk, g, op, h),
                    32'({rsp_retry, rsp_shared, fwd_valid}), 32'(e));
              check("R1 valid", 32'(rsp_valid), 1);
              if (fwd_valid) begin
                check("R3 fwd_addr", 32'(fwd_addr), 32'(a));
                check("R5 fwd_op", 32'(fwd_op), op);
                do_release();
                check("R10 released", 32'(fwd_valid), 0);
              end
              n++;
            end

    // R8: overwrite of an entry drops the old tag
    do_upd(mk_addr(9, 4, 0, 0), 3, 3);
    do_upd(mk_addr(10, 4, 0, 0), 1, 3);
    do_snoop(mk_addr(9, 4, 0, 0), 0);
    check("R8 old tag misses", 32'({rsp_retry, rsp_shared, fwd_valid}), 0);
    do_snoop(mk_addr(10, 4, 0, 0), 0);
    check("R8 new entry S shared", 32'({rsp_retry, rsp_shared, fwd_valid}), 32'(3'b010));

    // pending-forward collisions
    la = mk_addr(20, 1, 0, 4);
    lb = mk_addr(21, 2, 0, 8);
    do_upd(mk_addr(20, 1, 0, 0), 2, 3);
    do_upd(mk_addr(21, 2, 0, 0), 3, 3);
    do_upd(mk_addr(22, 5, 0, 0), 1, 3);
    do_snoop(la, 0);
    check("R3 launch", 32'({rsp_retry, rsp_shared, fwd_valid}), 32'(3'b101));
    do_snoop(la + 16, 0);
    check("R9 same granule retry", 32'({rsp_retry, rsp_shared}), 32'(2'b10));
    check("R9 fwd kept", 32'(fwd_addr), 32'(la));
    do_snoop(mk_addr(22, 5, 0, 3), 0);
    check("R4 S read while busy", 32'({rsp_retry, rsp_shared}), 32'(2'b01));
    do_snoop(la + 32, 3);
    check("R10 other granule retry", 32'({rsp_retry, rsp_shared}), 32'(2'b10));
    check("R10 fwd_addr held", 32'(fwd_addr), 32'(la));
    do_snoop(lb, 0);
    check("R10 other line retry", 32'({rsp_retry, rsp_shared}), 32'(2'b10));
    check("R10 fwd_op held", 32'(fwd_op), 0);
    check("R10 still valid", 32'(fwd_valid), 1);
    fwd_ready = 1'b1;
    do_snoop(lb, 2);
    fwd_ready = 1'b0;
    check("R11 new fwd valid", 32'(fwd_valid), 1);
    check("R11 new fwd addr", 32'(fwd_addr), 32'(lb));
    check("R11 new fwd op", 32'(fwd_op), 2);
    check("R12 retry only", 32'({rsp_retry, rsp_shared}), 32'(2'b10));
    do_release();
    check("R10 drained", 32'(fwd_valid), 0);
    @(negedge clk);
    check("R1 idle end", 32'(rsp_valid), 0);
    finish_run();
  end

endmodule